// File: doc/BRIEF.md
# Idle-Channel Region Prefetch Scheduler

This block sits next to a last-level cache controller and turns each demand miss into a burst of background fetches for the rest of the enclosing memory region. A miss is forwarded to memory at once. At the same time, the region it belongs to is recorded in a small table. The table keeps one pending bit for every block of that region that the cache reported absent. A selector scans the table each cycle. Among the entries that have a block whose DRAM bank is ready, it picks the oldest one, and within that entry it takes the lowest pending block. A one-slot output stage then decides what goes to memory next. A demand miss always wins. A prefetch goes out only when no miss is waiting and the channel reports idle.

The cache supplies its presence information for the missed region as a bit vector that travels with the miss. Demand requests carry the most-recently-used insertion code. Prefetch requests carry the least-recently-used code, so speculative data is the first data the cache evicts.

Both streams use valid/ready handshakes. Miss input: a miss is taken on a cycle where `miss_valid` and `miss_ready` are both high. `miss_ready` is high whenever the output slot is empty or is being drained in that cycle. Request output: `req_valid` stays high, and every request field stays constant, until `req_ready` is seen high at a clock edge. Back-pressure on the request port therefore stalls the miss port directly.

Top module: `rps_scheduler`

## Requirements
- R1: An accepted miss appears as the next request. It carries the miss address, `req_pref`=0 and insertion code 2'b00 (most recently used). A waiting miss always takes the output slot ahead of any prefetch.
- R2: The block address splits into a region number (bits [15:4]) and a block index (bits [3:0]). A miss to a region not in the table records that region. Its pending blocks are the blocks whose `miss_present` bit is 0, minus the missed block itself.
- R3: A prefetch request carries `req_pref`=1, insertion code 2'b11 (least recently used) and the address {region, block}. Within one entry, blocks go out in ascending block order, and each block goes out once.
- R4: A prefetch enters the output slot only in a cycle where `chan_idle`=1 and `miss_valid`=0.
- R5: A block's bank is bits [1:0] of its block address. A block whose bank bit in `bank_ready` is 0 is skipped in that cycle. Ready blocks in the same entry and in other entries still go out.
- R6: Each entry has a 4-bit age that starts at 0 and saturates. All ages step up by one every time a request enters the slot. The eligible entry with the greatest age wins, and on equal ages the lower entry index wins.
- R7: A miss to a region already in the table resets that entry's age to 0. It clears that block's pending bit and leaves the other pending bits unchanged.
- R8: The table holds 4 entries. A new region takes the lowest free entry if one exists. Otherwise it replaces the entry with the fewest pending blocks, and on equal counts the lower index.
- R9: An entry whose pending bits are all 0 is free and produces no further prefetches.
- R10: While `req_valid`=1 and `req_ready`=0, the request fields stay unchanged and `miss_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A demand miss is offered |
| miss_ready | output | 1 | The miss is taken this cycle |
| miss_addr | input | 16 | Block address of the miss |
| miss_present | input | 16 | Per-block cache presence for the missed region |
| bank_ready | input | 4 | One bit per DRAM bank, 1 = bank can take an access |
| chan_idle | input | 1 | The memory channel has a free slot |
| req_valid | output | 1 | Request slot holds a request |
| req_ready | input | 1 | Memory side accepts the request |
| req_addr | output | 16 | Block address of the request |
| req_pref | output | 1 | 1 = prefetch, 0 = demand |
| req_ins | output | 2 | Cache insertion position, 00 = MRU, 11 = LRU |

## Verification
Errors in the table or the selector never show up as protocol faults at the ports; they only show up in the order of requests. A stale or mis-cleared pending bit shows as a missing, duplicated or out-of-order prefetch address, visible within a few cycles of the channel going idle. A wrong age or tie-break shows as regions interleaving in the wrong order. The saturation corner only shows up after about a dozen issues. For that reason the bench drains several regions back to back, records every accepted request, and compares the whole address sequence against a list computed from the block rules.

// File: rtl/rps_pkg.sv
package rps_pkg;
  typedef enum logic [1:0] {
    INS_MRU  = 2'd0,
    INS_SMRU = 2'd1,
    INS_SLRU = 2'd2,
    INS_LRU  = 2'd3
  } ins_pos_e;
endpackage

// File: rtl/rps_region_queue.sv
module rps_region_queue #(
  parameter int N_ENT = 4,
  parameter int BLK   = 16,
  parameter int REG_W = 12,
  parameter int AGE_W = 4,
  localparam int OFS_W = $clog2(BLK),
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             alloc_en,
  input  logic [REG_W-1:0]                 alloc_region,
  input  logic [BLK-1:0]                   alloc_pend,
  input  logic [OFS_W-1:0]                 alloc_ofs,
  input  logic                             pf_clr_en,
  input  logic [IDX_W-1:0]                 pf_clr_idx,
  input  logic [OFS_W-1:0]                 pf_clr_ofs,
  input  logic                             tick,
  output logic [N_ENT-1:0][BLK-1:0]        ent_pend,
  output logic [N_ENT-1:0][REG_W-1:0]      ent_region,
  output logic [N_ENT-1:0][AGE_W-1:0]      ent_age
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic [N_ENT-1:0][BLK-1:0]   pend_q;
  logic [N_ENT-1:0][REG_W-1:0] region_q;
  logic [N_ENT-1:0][AGE_W-1:0] age_q;

  logic             hit_found, free_found;
  logic [IDX_W-1:0] hit_idx, free_idx, vic_idx, tgt_idx;
  logic [OFS_W:0]   vic_cnt;
  logic [BLK-1:0]   miss_mask;
  logic             dup_flag;

  function automatic logic [OFS_W:0] popcnt(input logic [BLK-1:0] v);
    logic [OFS_W:0] c;
    c = '0;
    for (int i = 0; i < BLK; i++) c = c + {{OFS_W{1'b0}}, v[i]};
    return c;
  endfunction

  // target entry: existing region, else lowest free, else fewest pending
  always_comb begin
    hit_found  = 1'b0;
    hit_idx    = '0;
    free_found = 1'b0;
    free_idx   = '0;
    vic_idx    = '0;
    vic_cnt    = '1;
    for (int e = 0; e < N_ENT; e++) begin
      if (!hit_found && (|pend_q[e]) && region_q[e] == alloc_region) begin
        hit_found = 1'b1;
        hit_idx   = IDX_W'(e);
      end
      if (!free_found && pend_q[e] == '0) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(e);
      end
      if (popcnt(pend_q[e]) < vic_cnt) begin
        vic_cnt = popcnt(pend_q[e]);
        vic_idx = IDX_W'(e);
      end
    end
    tgt_idx   = hit_found ? hit_idx : (free_found ? free_idx : vic_idx);
    miss_mask = ~(BLK'(1) << alloc_ofs);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= '0;
      region_q <= '0;
      age_q    <= '0;
    end else begin
      for (int e = 0; e < N_ENT; e++) begin
        if (alloc_en && tgt_idx == IDX_W'(e)) begin
          age_q[e] <= '0;
          if (hit_found) begin
            pend_q[e] <= pend_q[e] & miss_mask;
          end else begin
            pend_q[e]   <= alloc_pend & miss_mask;
            region_q[e] <= alloc_region;
          end
        end else begin
          if (tick && age_q[e] != AGE_MAX) age_q[e] <= age_q[e] + 1'b1;
          if (pf_clr_en && pf_clr_idx == IDX_W'(e)) pend_q[e][pf_clr_ofs] <= 1'b0;
        end
      end
    end
  end

  assign ent_pend   = pend_q;
  assign ent_region = region_q;
  assign ent_age    = age_q;

  always_comb begin
    dup_flag = 1'b0;
    for (int a = 0; a < N_ENT; a++)
      for (int b = a + 1; b < N_ENT; b++)
        if ((|pend_q[a]) && (|pend_q[b]) && region_q[a] == region_q[b]) dup_flag = 1'b1;
  end

  AST_NO_DUP_REGION: assert property (@(posedge clk) disable iff (!rst_n) !dup_flag); // R2

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent_chk
    AST_AGE_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_en && tgt_idx == IDX_W'(g)) |=> (age_q[g] == '0)); // R7
    AST_PF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (pf_clr_en && pf_clr_idx == IDX_W'(g)) |=> !pend_q[g][$past(pf_clr_ofs)]); // R3
  end
endmodule

// File: rtl/rps_prioritizer.sv
module rps_prioritizer #(
  parameter int N_ENT    = 4,
  parameter int BLK      = 16,
  parameter int REG_W    = 12,
  parameter int AGE_W    = 4,
  parameter int N_BANKS  = 4,
  parameter int BANK_LSB = 0,
  localparam int OFS_W  = $clog2(BLK),
  localparam int IDX_W  = $clog2(N_ENT),
  localparam int BANK_W = $clog2(N_BANKS),
  localparam int ADDR_W = REG_W + OFS_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_ENT-1:0][BLK-1:0]   ent_pend,
  input  logic [N_ENT-1:0][REG_W-1:0] ent_region,
  input  logic [N_ENT-1:0][AGE_W-1:0] ent_age,
  input  logic [N_BANKS-1:0]          bank_ready,
  output logic                        cand_valid,
  output logic [IDX_W-1:0]            cand_idx,
  output logic [OFS_W-1:0]            cand_ofs
);
  logic [N_ENT-1:0][BLK-1:0] elig;
  logic [AGE_W-1:0]          best_age;

  function automatic logic [BANK_W-1:0] bank_of(input logic [REG_W-1:0] r, input int b);
    logic [ADDR_W-1:0] full;
    full = {r, OFS_W'(b)};
    return full[BANK_LSB +: BANK_W];
  endfunction

  always_comb begin
    for (int e = 0; e < N_ENT; e++)
      for (int b = 0; b < BLK; b++)
        elig[e][b] = ent_pend[e][b] & bank_ready[bank_of(ent_region[e], b)];
  end

  // oldest eligible entry, strict compare keeps the lowest index on a tie
  always_comb begin
    cand_valid = 1'b0;
    cand_idx   = '0;
    best_age   = '0;
    cand_ofs   = '0;
    for (int e = 0; e < N_ENT; e++) begin
      if ((|elig[e]) && (!cand_valid || ent_age[e] > best_age)) begin
        cand_valid = 1'b1;
        cand_idx   = IDX_W'(e);
        best_age   = ent_age[e];
      end
    end
    for (int b = BLK - 1; b >= 0; b--)
      if (elig[cand_idx][b]) cand_ofs = OFS_W'(b);
  end

  AST_PICK_READY: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid |-> (ent_pend[cand_idx][cand_ofs] &&
                    bank_ready[bank_of(ent_region[cand_idx], int'(cand_ofs))])); // R5
endmodule

// File: rtl/rps_arbiter.sv
module rps_arbiter
  import rps_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic              chan_idle,
  input  logic              cand_valid,
  input  logic [ADDR_W-1:0] cand_addr,
  input  logic              req_ready,
  output logic              miss_ready,
  output logic              dem_issue,
  output logic              pf_issue,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic              req_pref,
  output logic [1:0]        req_ins
);
  logic              valid_q, pref_q;
  logic [ADDR_W-1:0] addr_q;
  ins_pos_e          ins_q;
  logic              slot_free;

  assign slot_free  = !valid_q || req_ready;
  assign dem_issue  = slot_free && miss_valid;
  assign pf_issue   = slot_free && !miss_valid && chan_idle && cand_valid;
  assign miss_ready = slot_free;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      pref_q  <= 1'b0;
      addr_q  <= '0;
      ins_q   <= INS_MRU;
    end else if (dem_issue) begin
      valid_q <= 1'b1;
      pref_q  <= 1'b0;
      addr_q  <= miss_addr;
      ins_q   <= INS_MRU;
    end else if (pf_issue) begin
      valid_q <= 1'b1;
      pref_q  <= 1'b1;
      addr_q  <= cand_addr;
      ins_q   <= INS_LRU;
    end else if (req_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign req_valid = valid_q;
  assign req_addr  = addr_q;
  assign req_pref  = pref_q;
  assign req_ins   = ins_q;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_pref) && $stable(req_ins))); // R10
  AST_DEMAND_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready) |=> (req_valid && !req_pref && req_addr == $past(miss_addr))); // R1
  AST_PF_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_ready && !miss_valid && !chan_idle) |=> !req_valid); // R4
  AST_INS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_pref ? (req_ins == 2'd3) : (req_ins == 2'd0))); // R3
endmodule

// File: rtl/rps_scheduler.sv
module rps_scheduler #(
  parameter int ADDR_W   = 16,
  parameter int N_ENT    = 4,
  parameter int BLK      = 16,
  parameter int AGE_W    = 4,
  parameter int N_BANKS  = 4,
  parameter int BANK_LSB = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               miss_valid,
  output logic               miss_ready,
  input  logic [ADDR_W-1:0]  miss_addr,
  input  logic [BLK-1:0]     miss_present,
  input  logic [N_BANKS-1:0] bank_ready,
  input  logic               chan_idle,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [ADDR_W-1:0]  req_addr,
  output logic               req_pref,
  output logic [1:0]         req_ins
);
  localparam int OFS_W = $clog2(BLK);
  localparam int REG_W = ADDR_W - OFS_W;
  localparam int IDX_W = $clog2(N_ENT);

  logic [N_ENT-1:0][BLK-1:0]   ent_pend;
  logic [N_ENT-1:0][REG_W-1:0] ent_region;
  logic [N_ENT-1:0][AGE_W-1:0] ent_age;
  logic                        cand_valid;
  logic [IDX_W-1:0]            cand_idx;
  logic [OFS_W-1:0]            cand_ofs;
  logic [ADDR_W-1:0]           cand_addr;
  logic                        dem_issue, pf_issue;

  assign cand_addr = {ent_region[cand_idx], cand_ofs};

  rps_region_queue #(
    .N_ENT(N_ENT), .BLK(BLK), .REG_W(REG_W), .AGE_W(AGE_W)
  ) u_queue (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_en     (dem_issue),
    .alloc_region (miss_addr[ADDR_W-1:OFS_W]),
    .alloc_pend   (~miss_present),
    .alloc_ofs    (miss_addr[OFS_W-1:0]),
    .pf_clr_en    (pf_issue),
    .pf_clr_idx   (cand_idx),
    .pf_clr_ofs   (cand_ofs),
    .tick         (dem_issue | pf_issue),
    .ent_pend     (ent_pend),
    .ent_region   (ent_region),
    .ent_age      (ent_age)
  );

  rps_prioritizer #(
    .N_ENT(N_ENT), .BLK(BLK), .REG_W(REG_W), .AGE_W(AGE_W),
    .N_BANKS(N_BANKS), .BANK_LSB(BANK_LSB)
  ) u_prio (
    .clk        (clk),
    .rst_n      (rst_n),
    .ent_pend   (ent_pend),
    .ent_region (ent_region),
    .ent_age    (ent_age),
    .bank_ready (bank_ready),
    .cand_valid (cand_valid),
    .cand_idx   (cand_idx),
    .cand_ofs   (cand_ofs)
  );

  rps_arbiter #(
    .ADDR_W(ADDR_W)
  ) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_valid (miss_valid),
    .miss_addr  (miss_addr),
    .chan_idle  (chan_idle),
    .cand_valid (cand_valid),
    .cand_addr  (cand_addr),
    .req_ready  (req_ready),
    .miss_ready (miss_ready),
    .dem_issue  (dem_issue),
    .pf_issue   (pf_issue),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_pref   (req_pref),
    .req_ins    (req_ins)
  );
endmodule

// File: tb/rps_scheduler_test.sv
module rps_scheduler_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_valid = 1'b0;
  logic        miss_ready;
  logic [15:0] miss_addr = '0;
  logic [15:0] miss_present = '0;
  logic [3:0]  bank_ready = 4'hF;
  logic        chan_idle = 1'b0;
  logic        req_valid;
  logic        req_ready = 1'b1;
  logic [15:0] req_addr;
  logic        req_pref;
  logic [1:0]  req_ins;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [15:0] log_addr [0:63];
  logic        log_pref [0:63];
  logic [1:0]  log_ins  [0:63];
  int          log_n = 0;

  logic [15:0] exp_addr [0:63];
  logic        exp_pref [0:63];
  int          exp_n = 0;

  always #10 clk = ~clk;

  rps_scheduler uut (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_addr(miss_addr), .miss_present(miss_present), .bank_ready(bank_ready),
    .chan_idle(chan_idle), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_pref(req_pref), .req_ins(req_ins)
  );

  always @(negedge clk) begin
    if (req_valid && req_ready && log_n < 64) begin
      log_addr[log_n] = req_addr;
      log_pref[log_n] = req_pref;
      log_ins[log_n]  = req_ins;
      log_n = log_n + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      n_chk = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run did not finish (act %0d cycles, exp fewer)", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: act 0x%0h exp 0x%0h", req, act, expv);
    end
  endtask

  task automatic clear_log();
    @(posedge clk);
    #1;
    log_n = 0;
    exp_n = 0;
  endtask

  task automatic do_miss(input logic [15:0] a, input logic [15:0] pres);
    @(negedge clk);
    miss_valid   = 1'b1;
    miss_addr    = a;
    miss_present = pres;
    @(posedge clk);
    #1;
    miss_valid = 1'b0;
  endtask

  task automatic exp_push(input logic [15:0] a, input logic p);
    exp_addr[exp_n] = a;
    exp_pref[exp_n] = p;
    exp_n = exp_n + 1;
  endtask

  // prefetches of region r for blocks lo..hi, skipping one block
  task automatic exp_range(input logic [11:0] r, input int lo, input int hi, input int skip);
    for (int b = lo; b <= hi; b++)
      if (b != skip) exp_push({r, 4'(b)}, 1'b1);
  endtask

  task automatic compare_log(input string req);
    chk(log_n == exp_n, {req, " count"}, log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      chk(log_addr[i] == exp_addr[i], {req, " addr"}, log_addr[i], exp_addr[i]);
      chk(log_pref[i] == exp_pref[i], {req, " kind"}, log_pref[i], exp_pref[i]);
      chk(log_ins[i] == (exp_pref[i] ? 2'd3 : 2'd0), {req, " ins"}, log_ins[i], exp_pref[i] ? 3 : 0);
    end
  endtask

  function automatic logic [15:0] mk_present(input int m);
    logic [15:0] base;
    base = 16'hA5C3 ^ 16'(m * 16'h0911);
    return (base << m) | (base >> (16 - m));
  endfunction

  initial begin
    // reset state
    repeat (3) @(posedge clk);
    #1;
    chk(req_valid == 1'b0, "R10 reset valid", req_valid, 0);
    chk(miss_ready == 1'b1, "R10 reset miss_ready", miss_ready, 1);
    rst_n = 1'b1;

    // R1 R2 R3: sweep missed block index with varying presence patterns
    chan_idle = 1'b1;
    for (int m = 0; m < 16; m++) begin
      logic [15:0] pres;
      logic [11:0] r;
      pres = mk_present(m);
      r = 12'(16 + m);
      clear_log();
      do_miss({r, 4'(m)}, pres);
      repeat (20) @(negedge clk);
      exp_push({r, 4'(m)}, 1'b0);
      for (int b = 0; b < 16; b++)
        if (!pres[b] && b != m) exp_push({r, 4'(b)}, 1'b1);
      compare_log("R1 R2 R3 sweep");
    end

    // R5: only bank 2 ready, then all banks
    clear_log();
    bank_ready = 4'b0100;
    do_miss(16'h0200, 16'h0000);
    repeat (20) @(negedge clk);
    exp_push(16'h0200, 1'b0);
    exp_push(16'h0202, 1'b1); exp_push(16'h0206, 1'b1);
    exp_push(16'h020A, 1'b1); exp_push(16'h020E, 1'b1);
    compare_log("R5 bank mask");
    clear_log();
    bank_ready = 4'hF;
    repeat (20) @(negedge clk);
    for (int b = 1; b < 16; b++)
      if (b[1:0] != 2'd2) exp_push({12'h020, 4'(b)}, 1'b1);
    compare_log("R5 remaining banks");

    // R10: back-pressure holds the demand, stalls misses
    clear_log();
    do_miss(16'h0500, 16'h0000);
    req_ready = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(req_valid && req_addr == 16'h0500 && !req_pref && req_ins == 2'd0,
          "R10 held request", req_addr, 16'h0500);
      chk(miss_ready == 1'b0, "R10 miss stalled", miss_ready, 0);
    end
    @(posedge clk);
    #1;
    req_ready = 1'b1;
    repeat (22) @(negedge clk);
    exp_push(16'h0500, 1'b0);
    exp_range(12'h050, 1, 15, -1);
    compare_log("R10 drain after stall");

    // R1 R7: demand to a pending block overtakes prefetches and clears it
    clear_log();
    do_miss(16'h0600, 16'h0000);
    repeat (3) @(negedge clk);
    do_miss(16'h060C, 16'h0000);
    @(negedge clk);
    chk(req_valid && !req_pref && req_addr == 16'h060C, "R1 demand beats prefetch", req_addr, 16'h060C);
    repeat (25) @(negedge clk);
    begin
      int pf_cnt;
      int bad;
      pf_cnt = 0;
      bad = 0;
      for (int i = 0; i < log_n; i++) begin
        if (log_pref[i]) pf_cnt++;
        if (log_pref[i] && log_addr[i] == 16'h060C) bad++;
      end
      chk(pf_cnt == 14, "R7 prefetch count after demand", pf_cnt, 14);
      chk(bad == 0, "R7 demanded block not prefetched", bad, 0);
    end

    // R4 R6 R7: busy channel, then age order with refresh
    clear_log();
    chan_idle = 1'b0;
    do_miss(16'h0400, 16'h0000);
    do_miss(16'h0410, 16'hFF00);
    do_miss(16'h0405, 16'h0000);
    repeat (12) @(negedge clk);
    chk(log_n == 3, "R4 no prefetch while busy", log_n, 3);
    chan_idle = 1'b1;
    repeat (30) @(negedge clk);
    exp_push(16'h0400, 1'b0); exp_push(16'h0410, 1'b0); exp_push(16'h0405, 1'b0);
    exp_range(12'h041, 1, 7, -1);
    exp_range(12'h040, 1, 15, 5);
    compare_log("R6 R7 age order");

    // R8 R6: replacement of fewest-pending entry, saturation tie to lower index
    clear_log();
    chan_idle = 1'b0;
    do_miss(16'h0700, ~(16'h001F << 1));
    do_miss(16'h0710, ~(16'h0003 << 1));
    do_miss(16'h0720, ~(16'h007F << 1));
    do_miss(16'h0730, ~(16'h01FF << 1));
    do_miss(16'h0740, ~(16'h000F << 1));
    repeat (4) @(negedge clk);
    chan_idle = 1'b1;
    repeat (35) @(negedge clk);
    exp_push(16'h0700, 1'b0); exp_push(16'h0710, 1'b0); exp_push(16'h0720, 1'b0);
    exp_push(16'h0730, 1'b0); exp_push(16'h0740, 1'b0);
    exp_range(12'h070, 1, 5, -1);
    exp_range(12'h072, 1, 7, -1);
    exp_range(12'h073, 1, 3, -1);
    exp_range(12'h074, 1, 4, -1);
    exp_range(12'h073, 4, 9, -1);
    compare_log("R8 R6 replacement and tie");

    // R9: all entries drained, nothing more issued
    clear_log();
    repeat (10) @(negedge clk);
    chk(log_n == 0, "R9 drained entries idle", log_n, 0);
    chk(req_valid == 1'b0, "R9 slot empty", req_valid, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule